// File: doc/BRIEF.md
# Masked XON/XOFF Flow Controller

This block watches the character stream coming out of a serial receiver and decides whether the local transmitter may keep sending. It holds two programmable control codes, one that resumes traffic and one that pauses it. Each code has its own mask, and a mask bit set to 1 makes that bit position a don't-care. The comparison covers only the bit positions that lie inside the programmed character length. Characters are right-justified, so a short character occupies the low bits.

A match against either code produces a one-cycle report pulse and updates an internal flow state. The transmitter does not see that state directly. It sees a gated copy, `tx_enable`, which changes only in a cycle where the transmitter signals that it is at a character boundary. A character that is already being sent therefore always finishes. The four configuration registers are loaded through a narrow write port whose address has already been decoded.

Top module: `xonoff_flow_ctrl`

## Requirements
- R1: After reset the resume code is 8'h11 and the pause code is 8'h13. A cycle with `cfg_we`=1 writes `cfg_wdata` into the register chosen by `cfg_sel`: 0 is the resume code, 1 is the pause code, 2 is the resume mask and 3 is the pause mask.
- R2: `char_len` selects the character length: 0 is 5 bits, 1 is 6 bits, 2 is 7 bits and 3 is 8 bits. Received bits at or above that length never affect a match.
- R3: A mask bit of 1 excludes that bit position from the comparison with its own code only. A mask bit of 0 requires equality at that position.
- R4: Reset clears both masks, so every bit within the character length is compared.
- R5: A pause-code match clears `flow_state`, and a resume-code match sets it. `flow_state` and `tx_enable` are both 1 after reset.
- R6: When a character matches both codes, the pause result wins. `flow_state` goes to 0, `xoff_hit` pulses and `xon_hit` stays 0.
- R7: `xon_hit` and `xoff_hit` are high for exactly the one cycle that follows the clock edge at which `rx_valid`=1 was sampled with a matching character. They are never high otherwise.
- R8: `tx_enable` takes the value `flow_state` held before each clock edge at which `tx_boundary`=1. At every other edge it keeps its value.
- R9: A valid character that matches neither code leaves `flow_state` unchanged and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 resume code, 1 pause code, 2 resume mask, 3 pause mask |
| cfg_wdata | input | 8 | Configuration write data |
| char_len | input | 2 | Character length: 0 is 5, 1 is 6, 2 is 7, 3 is 8 bits |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character, right-justified |
| tx_boundary | input | 1 | Transmitter is at a character boundary |
| flow_state | output | 1 | Raw flow state after the most recent match |
| tx_enable | output | 1 | Flow state as applied to the transmitter |
| xon_hit | output | 1 | Resume-code match pulse |
| xoff_hit | output | 1 | Pause-code match pulse |

## Verification
The hardest case to reach is a character that matches both codes at once while the upper bits are ignored. Random data almost never lands on that. The stimulus builds such characters on purpose. It starts from a programmed code, flips bits that are masked off or above the character length, and sometimes programs both codes with the same value. Random `tx_boundary` patterns run alongside flow changes, so that `tx_enable` must hold through several pause/resume transitions that happen between boundaries.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
   localparam int unsigned XFC_NUM_REGS = 4;
   typedef enum logic [1:0] {
      SEL_RESUME_CODE = 2'd0,
      SEL_PAUSE_CODE  = 2'd1,
      SEL_RESUME_MASK = 2'd2,
      SEL_PAUSE_MASK  = 2'd3
   } xfc_sel_e;
   localparam int unsigned CODE_RESUME = 0;
   localparam int unsigned CODE_PAUSE  = 1;
endpackage

// File: rtl/xfc_cfg_regs.sv
module xfc_cfg_regs #(
   parameter int unsigned DATA_W       = 8,
   parameter logic [7:0]  RESUME_RESET = 8'h11,
   parameter logic [7:0]  PAUSE_RESET  = 8'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] code_q [2],
   output logic [DATA_W-1:0] mask_q [2]
);
   import xfc_pkg::*;

   localparam logic [DATA_W-1:0] RST_RESUME = DATA_W'(RESUME_RESET);
   localparam logic [DATA_W-1:0] RST_PAUSE  = DATA_W'(PAUSE_RESET);

   for (genvar r = 0; r < 2; r++) begin : g_code
      localparam logic [DATA_W-1:0] RVAL = (r == CODE_RESUME) ? RST_RESUME : RST_PAUSE;
      localparam logic [1:0] CSEL = 2'(r);
      localparam logic [1:0] MSEL = 2'(r + 2);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q[r] <= RVAL;
            mask_q[r] <= '0;
         end else if (cfg_we) begin
            if (cfg_sel == CSEL) code_q[r] <= cfg_wdata;
            if (cfg_sel == MSEL) mask_q[r] <= cfg_wdata;
         end
      end
   end
endmodule

// File: rtl/xfc_char_match.sv
module xfc_char_match #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned LEN_W   = 2,
   parameter int unsigned MIN_LEN = 5
) (
   input  logic [DATA_W-1:0] rx_data,
   input  logic [DATA_W-1:0] code,
   input  logic [DATA_W-1:0] mask,
   input  logic [LEN_W-1:0]  char_len,
   output logic              hit
);
   logic [DATA_W-1:0] len_bits;
   logic [DATA_W-1:0] care;

   always_comb begin
      int unsigned width;
      width = MIN_LEN + int'(char_len);
      for (int unsigned i = 0; i < DATA_W; i++) begin
         len_bits[i] = (i < width);
      end
   end

   assign care = len_bits & ~mask;
   assign hit  = ((rx_data ^ code) & care) == '0;
endmodule

// File: rtl/xfc_flow_track.sv
module xfc_flow_track #(
   parameter bit GATE_AT_BOUNDARY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_valid,
   input  logic resume_match,
   input  logic pause_match,
   input  logic tx_boundary,
   output logic flow_state,
   output logic tx_enable,
   output logic xon_hit,
   output logic xoff_hit
);
   logic pause_ev;
   logic resume_ev;

   assign pause_ev  = rx_valid & pause_match;
   assign resume_ev = rx_valid & resume_match & ~pause_match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flow_state <= 1'b1;
         xon_hit    <= 1'b0;
         xoff_hit   <= 1'b0;
      end else begin
         xoff_hit <= pause_ev;
         xon_hit  <= resume_ev;
         if (pause_ev)       flow_state <= 1'b0;
         else if (resume_ev) flow_state <= 1'b1;
      end
   end

   if (GATE_AT_BOUNDARY) begin : g_gated
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           tx_enable <= 1'b1;
         else if (tx_boundary) tx_enable <= flow_state;
      end
   end else begin : g_direct
      logic unused_boundary;
      assign unused_boundary = tx_boundary;
      assign tx_enable = flow_state;
   end
endmodule

// File: rtl/xonoff_flow_ctrl.sv
module xonoff_flow_ctrl #(
   parameter int unsigned DATA_W           = 8,
   parameter int unsigned LEN_W            = 2,
   parameter int unsigned MIN_LEN          = 5,
   parameter logic [7:0]  RESUME_RESET     = 8'h11,
   parameter logic [7:0]  PAUSE_RESET      = 8'h13,
   parameter bit          GATE_AT_BOUNDARY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [LEN_W-1:0]  char_len,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              tx_boundary,
   output logic              flow_state,
   output logic              tx_enable,
   output logic              xon_hit,
   output logic              xoff_hit
);
   import xfc_pkg::*;

   localparam int unsigned MAX_LEN = MIN_LEN + (1 << LEN_W) - 1;

   if (MIN_LEN < 1 || MIN_LEN > DATA_W) begin : g_bad_min
      $error("MIN_LEN must lie in 1..DATA_W");
   end
   if (MAX_LEN < DATA_W) begin : g_bad_range
      $error("char_len range cannot reach DATA_W");
   end
   if (DATA_W > 8) begin : g_bad_width
      $error("reset codes are 8 bits wide");
   end

   logic [DATA_W-1:0] code_q [2];
   logic [DATA_W-1:0] mask_q [2];
   logic [1:0]        match;

   xfc_cfg_regs #(
      .DATA_W(DATA_W), .RESUME_RESET(RESUME_RESET), .PAUSE_RESET(PAUSE_RESET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .code_q(code_q), .mask_q(mask_q)
   );

   for (genvar c = 0; c < 2; c++) begin : g_match
      xfc_char_match #(
         .DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
      ) u_cmp (
         .rx_data(rx_data), .code(code_q[c]), .mask(mask_q[c]),
         .char_len(char_len), .hit(match[c])
      );
   end

   xfc_flow_track #(.GATE_AT_BOUNDARY(GATE_AT_BOUNDARY)) u_flow (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
      .resume_match(match[CODE_RESUME]), .pause_match(match[CODE_PAUSE]),
      .tx_boundary(tx_boundary), .flow_state(flow_state),
      .tx_enable(tx_enable), .xon_hit(xon_hit), .xoff_hit(xoff_hit)
   );
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker (
   input logic clk,
   input logic rst_n,
   input logic rx_valid,
   input logic tx_boundary,
   input logic flow_state,
   input logic tx_enable,
   input logic xon_hit,
   input logic xoff_hit
);
   // R6
   one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xon_hit, xoff_hit}));
   // R7
   hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xon_hit || xoff_hit) |-> $past(rx_valid));
   // R5
   pause_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xoff_hit |-> !flow_state);
   // R5
   resume_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xon_hit |-> flow_state);
   // R8
   hold_off_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tx_boundary) |-> $stable(tx_enable));
   // R9
   flow_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flow_state) |-> (xon_hit || xoff_hit));
endmodule

bind xonoff_flow_ctrl xfc_checker u_chk (.*);

// File: tb/xonoff_flow_ctrl_test.sv
module xonoff_flow_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_sel = '0;
   logic [7:0] cfg_wdata = '0;
   logic [1:0] char_len = 2'd3;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       tx_boundary = 1'b0;
   logic       flow_state, tx_enable, xon_hit, xoff_hit;

   int compared = 0;
   int mismatched = 0;

   logic [7:0] m_code [2];
   logic [7:0] m_mask [2];
   logic       e_flow, e_tx, e_xon, e_xoff;

   always #5 clk = ~clk;

   xonoff_flow_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .char_len(char_len), .rx_valid(rx_valid),
      .rx_data(rx_data), .tx_boundary(tx_boundary), .flow_state(flow_state),
      .tx_enable(tx_enable), .xon_hit(xon_hit), .xoff_hit(xoff_hit)
   );

   function automatic logic [7:0] len_mask(input logic [1:0] cl);
      case (cl)
         2'd0: return 8'h1F;
         2'd1: return 8'h3F;
         2'd2: return 8'h7F;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic bit code_hit(input int idx, input logic [7:0] d, input logic [1:0] cl);
      return ((d ^ m_code[idx]) & len_mask(cl) & ~m_mask[idx]) == 8'h00;
   endfunction

   task automatic check(input string req, input logic act, input logic exp, input string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string req);
      check(req, flow_state, e_flow, "flow_state");
      check(req, tx_enable,  e_tx,   "tx_enable");
      check(req, xon_hit,    e_xon,  "xon_hit");
      check(req, xoff_hit,   e_xoff, "xoff_hit");
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      rx_valid = 1'b0; tx_boundary = 1'b0;
      @(posedge clk);
      if (sel < 2) m_code[sel] = val; else m_mask[sel-2] = val;
      e_xon = 1'b0; e_xoff = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic step(input logic v, input logic [7:0] d, input logic b, input string req);
      bit ph, rh;
      @(negedge clk);
      rx_valid = v; rx_data = d; tx_boundary = b;
      @(posedge clk);
      if (b) e_tx = e_flow;
      ph = v && code_hit(1, d, char_len);
      rh = v && code_hit(0, d, char_len) && !ph;
      e_xoff = ph; e_xon = rh;
      if (ph) e_flow = 1'b0; else if (rh) e_flow = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; tx_boundary = 1'b0;
      check_all(req);
   endtask

   initial begin
      #2_000_000;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      void'($urandom(32'd2573));
      m_code[0] = 8'h11; m_code[1] = 8'h13;
      m_mask[0] = 8'h00; m_mask[1] = 8'h00;
      e_flow = 1'b1; e_tx = 1'b1; e_xon = 1'b0; e_xoff = 1'b0;
      repeat (3) @(negedge clk);
      check_all("R5");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R5");

      // R4: masks cleared, near-miss of the reset pause code does nothing
      step(1'b1, 8'h12, 1'b1, "R4");
      step(1'b1, 8'h10, 1'b1, "R4");
      // R1: reset pause code at full length
      step(1'b1, 8'h13, 1'b0, "R1");
      // R8: boundary low keeps tx_enable high
      step(1'b0, 8'h00, 1'b0, "R8");
      step(1'b0, 8'h00, 1'b1, "R8");
      // R1: reset resume code; R7 pulse lasts one cycle
      step(1'b1, 8'h11, 1'b0, "R1");
      step(1'b0, 8'h11, 1'b0, "R7");
      step(1'b0, 8'h00, 1'b1, "R8");
      // R2: 5-bit length ignores upper bits
      char_len = 2'd0;
      step(1'b1, 8'hF3, 1'b1, "R2");
      step(1'b1, 8'hB1, 1'b1, "R2");
      char_len = 2'd3;
      step(1'b1, 8'hF3, 1'b1, "R2");
      // R3: pause mask bit0 makes 0x12 a pause match, resume not affected
      cfg_write(2'd3, 8'h01);
      step(1'b1, 8'h12, 1'b1, "R3");
      step(1'b1, 8'h10, 1'b1, "R3");
      // R6: identical codes -> pause wins
      cfg_write(2'd0, 8'h5A);
      cfg_write(2'd1, 8'h5A);
      cfg_write(2'd3, 8'h00);
      step(1'b1, 8'h5A, 1'b1, "R6");
      step(1'b1, 8'h5A, 1'b1, "R6");
      // R9: no match leaves state
      step(1'b1, 8'h00, 1'b1, "R9");
      // R7: matching data without strobe
      step(1'b0, 8'h5A, 1'b1, "R7");
      cfg_write(2'd2, 8'hFF);
      step(1'b1, 8'h77, 1'b1, "R6");

      // random phase
      for (int n = 0; n < 3000; n++) begin
         int r;
         logic [7:0] d;
         r = int'($urandom_range(0, 19));
         if (r == 0) begin
            logic [1:0] s;
            s = 2'($urandom_range(0, 3));
            cfg_write(s, (s >= 2) ? (8'($urandom) & 8'($urandom) & 8'($urandom)) : 8'($urandom));
         end else begin
            if (r == 1) char_len = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 3))
               0: d = m_code[0] ^ ((8'($urandom) & m_mask[0]) | (8'($urandom) & ~len_mask(char_len)));
               1: d = m_code[1] ^ ((8'($urandom) & m_mask[1]) | (8'($urandom) & ~len_mask(char_len)));
               default: d = 8'($urandom);
            endcase
            step(1'($urandom), d, 1'($urandom_range(0, 3) == 0), "R8");
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule